// File: doc/BRIEF.md
# Symmetric Complex FIR Filter Chain

This block filters a stream of complex samples through a cascade of identical low-pass FIR stages. Each sample carries a signed 16-bit real part and a signed 16-bit imaginary part. Both parts pass through the same real-valued coefficient set, and the two parts never mix. The coefficients are fixed when the design is elaborated. They rise linearly to a peak at the middle of the tap line and fall back in the same way. The coefficient set is symmetric, so each stage adds the two samples that share a coefficient before it multiplies. An odd tap count leaves a centre tap with no partner, and that tap is multiplied on its own.

A clocks-per-sample parameter time-shares the multipliers. With a value of K, each multiplier works through K coefficient pairs on successive cycles and the stage accepts a new sample at most once every K cycles. Fewer multipliers are needed, but throughput drops by the same factor. Each stage returns its wide sum to 16 bits with a fixed right shift, rounds half-up and saturates. It then passes the result to the next stage over a valid/ready handshake. The chain input and the chain output use AXI4-Stream style valid/ready handshakes.

Top module: `sym_cfir_chain`

## Requirements
- R1: A sample word carries its real part in bits [31:16] and its imaginary part in bits [15:0], both two's complement. The two parts are filtered independently with the same coefficients, so a part that is zero at every input stays zero at the output.
- R2: Coefficient k (0-based, k < NTAPS) equals min(k+1, NTAPS-k). For NTAPS=16, an isolated input impulse of amplitude 6400 on a single stage yields the output sequence 100*min(k+1, 16-k).
- R3: Each stage computes sum_k c[k]*x[n-k] exactly. It adds 2^(S-1), shifts right arithmetically by S, and S is floor(log2(sum of coefficients)). This is half-up rounding. For NTAPS=15 the coefficient sum is 64, so S=6 and a constant input is reproduced exactly.
- R4: A stage result above 32767 is replaced by 32767, and a result below -32768 is replaced by -32768.
- R5: Odd and even tap counts both give the exact convolution of R3. Mirrored taps are pre-added, and the centre tap of an odd count is used alone.
- R6: A stage accepts at most one sample every CPS cycles. When the output is never stalled and input is always offered, it accepts exactly one sample every CPS cycles.
- R7: With NSTAGES stages, the output equals the R3/R4 stage function applied NSTAGES times in series to the input stream.
- R8: Under any pattern of input valid and output ready, every accepted input produces exactly one output, in order, with nothing dropped or duplicated. A stalled output holds its value.
- R9: Reset clears every delay line to zero. Two clock cycles after reset is released, m_valid is 0 and s_ready is 1.
- R10: With all stages idle and m_ready held at 1, m_valid rises NSTAGES*(CPS+1)-1 rising edges after the edge at which the input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Chain accepts the input sample this cycle |
| s_data | input | 32 | Input sample, real in [31:16], imaginary in [15:0] |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts the output sample |
| m_data | output | 32 | Output sample, real in [31:16], imaginary in [15:0] |

## Verification
The assertions assume that the source obeys the handshake: once s_valid is raised with a word, the word is held until s_ready takes it. The assertions also assume that m_ready may change freely from cycle to cycle. The stimulus holds valid and data steady until a transfer occurs, and it toggles ready at random or keeps it high. No input is ever offered during reset or in the two synchronisation cycles after reset. The bench resets the design between scenarios, so every expected stream starts from an all-zero history.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

  localparam int SMP_W = 16;
  localparam int COEF_W = 16;

  // Triangular coefficient: ramps 1,2,.. to the centre, then back down.
  function automatic int tri_coef(input int ntaps, input int k);
    return (k + 1 < ntaps - k) ? (k + 1) : (ntaps - k);
  endfunction

  function automatic int tri_sum(input int ntaps);
    int s;
    s = 0;
    for (int k = 0; k < ntaps; k++) s += tri_coef(ntaps, k);
    return s;
  endfunction

  function automatic int floor_log2(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 30; i++) if ((v >> (i + 1)) != 0) r = i + 1;
    return r;
  endfunction

endpackage

// File: rtl/cfir_tap_line.sv
module cfir_tap_line #(
  parameter int NTAPS = 15,
  parameter int NPAIR = (NTAPS + 1) / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic signed [15:0] din_re,
  input  logic signed [15:0] din_im,
  output logic signed [16:0] pre_re [NPAIR],
  output logic signed [16:0] pre_im [NPAIR]
);

  logic signed [15:0] tap_re [NTAPS];
  logic signed [15:0] tap_im [NTAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) begin
        tap_re[k] <= '0;
        tap_im[k] <= '0;
      end
    end else if (shift_en) begin
      tap_re[0] <= din_re;
      tap_im[0] <= din_im;
      for (int k = 1; k < NTAPS; k++) begin
        tap_re[k] <= tap_re[k-1];
        tap_im[k] <= tap_im[k-1];
      end
    end
  end

  // Mirrored taps share a coefficient: add them before multiplying.
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    if ((NTAPS % 2 == 1) && (p == NPAIR - 1)) begin : g_centre
      assign pre_re[p] = {tap_re[p][15], tap_re[p]};
      assign pre_im[p] = {tap_im[p][15], tap_im[p]};
    end else begin : g_mirror
      assign pre_re[p] = {tap_re[p][15], tap_re[p]} + {tap_re[NTAPS-1-p][15], tap_re[NTAPS-1-p]};
      assign pre_im[p] = {tap_im[p][15], tap_im[p]} + {tap_im[NTAPS-1-p][15], tap_im[NTAPS-1-p]};
    end
  end

  // R8: each accepted sample moves down the line exactly one place
  a_r8_line_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (tap_re[1] == $past(tap_re[0])) && (tap_im[1] == $past(tap_im[0])));

endmodule

// File: rtl/cfir_mac_sched.sv
module cfir_mac_sched
  import cfir_pkg::*;
#(
  parameter int NTAPS = 15,
  parameter int NPAIR = (NTAPS + 1) / 2,
  parameter int CPS   = 1,
  parameter int PH_W  = 1,
  parameter int ACC_W = 38
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [16:0]      pre_re [NPAIR],
  input  logic signed [16:0]      pre_im [NPAIR],
  input  logic [PH_W-1:0]         phase,
  input  logic                    acc_en,
  input  logic                    acc_clr,
  output logic signed [ACC_W-1:0] sum_re,
  output logic signed [ACC_W-1:0] sum_im
);

  localparam int NMUL = (NPAIR + CPS - 1) / CPS;

  logic signed [32:0]      prod_re [NMUL];
  logic signed [32:0]      prod_im [NMUL];
  logic signed [ACC_W-1:0] part_re, part_im;
  logic signed [ACC_W-1:0] acc_re_q, acc_im_q, acc_re_d, acc_im_d;

  // Multiplier m serves pairs m*CPS .. m*CPS+CPS-1, one per phase.
  for (genvar m = 0; m < NMUL; m++) begin : g_mul
    logic signed [16:0] cand_re [CPS];
    logic signed [16:0] cand_im [CPS];
    logic signed [15:0] cand_c  [CPS];
    logic signed [16:0] sel_re, sel_im;
    logic signed [15:0] sel_c;

    for (genvar ph = 0; ph < CPS; ph++) begin : g_ph
      localparam int IDX = m * CPS + ph;
      if (IDX < NPAIR) begin : g_on
        assign cand_re[ph] = pre_re[IDX];
        assign cand_im[ph] = pre_im[IDX];
        assign cand_c[ph]  = 16'(tri_coef(NTAPS, IDX));
      end else begin : g_off
        assign cand_re[ph] = '0;
        assign cand_im[ph] = '0;
        assign cand_c[ph]  = '0;
      end
    end

    always_comb begin
      sel_re = cand_re[0];
      sel_im = cand_im[0];
      sel_c  = cand_c[0];
      for (int ph = 1; ph < CPS; ph++) begin
        if (phase == PH_W'(ph)) begin
          sel_re = cand_re[ph];
          sel_im = cand_im[ph];
          sel_c  = cand_c[ph];
        end
      end
    end

    assign prod_re[m] = 33'(sel_re) * 33'(sel_c);
    assign prod_im[m] = 33'(sel_im) * 33'(sel_c);
  end

  always_comb begin
    part_re = '0;
    part_im = '0;
    for (int m = 0; m < NMUL; m++) begin
      part_re = part_re + ACC_W'(prod_re[m]);
      part_im = part_im + ACC_W'(prod_im[m]);
    end
  end

  assign sum_re = acc_re_q + part_re;
  assign sum_im = acc_im_q + part_im;

  always_comb begin
    acc_re_d = acc_re_q;
    acc_im_d = acc_im_q;
    if (acc_clr) begin
      acc_re_d = '0;
      acc_im_d = '0;
    end else if (acc_en) begin
      acc_re_d = sum_re;
      acc_im_d = sum_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re_q <= '0;
      acc_im_q <= '0;
    end else begin
      acc_re_q <= acc_re_d;
      acc_im_q <= acc_im_d;
    end
  end

endmodule

// File: rtl/cfir_round_sat.sv
module cfir_round_sat #(
  parameter int ACC_W = 38,
  parameter int SHIFT = 6
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [15:0]      q
);

  localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'((1 << SHIFT) >> 1);

  logic signed [ACC_W:0] biased, shifted;
  logic [ACC_W-15:0]     hi;
  logic                  ovf;

  always_comb begin
    biased  = (ACC_W+1)'(acc) + HALF;
    shifted = biased >>> SHIFT;
    hi      = shifted[ACC_W:15];
    ovf     = !((&hi) || !(|hi));
    if (ovf) q = shifted[ACC_W] ? 16'sh8000 : 16'sh7fff;
    else     q = shifted[15:0];
  end

endmodule

// File: rtl/cfir_stage.sv
module cfir_stage
  import cfir_pkg::*;
#(
  parameter int NTAPS = 15,
  parameter int CPS   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_valid,
  output logic               i_ready,
  input  logic signed [15:0] i_re,
  input  logic signed [15:0] i_im,
  output logic               o_valid,
  input  logic               o_ready,
  output logic signed [15:0] o_re,
  output logic signed [15:0] o_im
);

  localparam int NPAIR = (NTAPS + 1) / 2;
  localparam int PH_W  = (CPS > 1) ? $clog2(CPS) : 1;
  localparam int SHIFT = floor_log2(tri_sum(NTAPS));
  localparam int ACC_W = 34 + $clog2(NTAPS);

  logic signed [16:0]      pre_re [NPAIR];
  logic signed [16:0]      pre_im [NPAIR];
  logic signed [ACC_W-1:0] sum_re, sum_im;
  logic signed [15:0]      rs_re, rs_im;

  logic            busy_q, busy_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            ov_q, ov_d;
  logic signed [15:0] ore_q, oim_q;
  logic            last_ph, out_free, accept, finish, acc_en;

  assign last_ph  = busy_q && (ph_q == PH_W'(CPS - 1));
  assign out_free = !ov_q || o_ready;
  assign i_ready  = !busy_q || (last_ph && out_free);
  assign accept   = i_valid && i_ready;
  assign finish   = last_ph && out_free;
  assign acc_en   = busy_q && !last_ph;

  cfir_tap_line #(.NTAPS(NTAPS), .NPAIR(NPAIR)) u_line (
    .clk(clk), .rst_n(rst_n), .shift_en(accept),
    .din_re(i_re), .din_im(i_im),
    .pre_re(pre_re), .pre_im(pre_im)
  );

  cfir_mac_sched #(.NTAPS(NTAPS), .NPAIR(NPAIR), .CPS(CPS), .PH_W(PH_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .pre_re(pre_re), .pre_im(pre_im),
    .phase(ph_q), .acc_en(acc_en), .acc_clr(finish),
    .sum_re(sum_re), .sum_im(sum_im)
  );

  cfir_round_sat #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_rs_re (.acc(sum_re), .q(rs_re));
  cfir_round_sat #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_rs_im (.acc(sum_im), .q(rs_im));

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    if (accept) begin
      busy_d = 1'b1;
      ph_d   = '0;
    end else if (finish) begin
      busy_d = 1'b0;
      ph_d   = '0;
    end else if (acc_en) begin
      ph_d   = ph_q + PH_W'(1);
    end
    ov_d = finish ? 1'b1 : (o_ready ? 1'b0 : ov_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      ov_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      ov_q   <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ore_q <= '0;
      oim_q <= '0;
    end else if (finish) begin
      ore_q <= rs_re;
      oim_q <= rs_im;
    end
  end

  assign o_valid = ov_q;
  assign o_re    = ore_q;
  assign o_im    = oim_q;

  // R6: no new sample while earlier phases of the current one remain
  a_r6_no_accept_midcalc: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_ph) |-> !i_ready);

  // R6: phase counter never leaves its schedule
  a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= PH_W'(CPS - 1));

  // R8: a stalled output keeps its word
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_re) && $stable(o_im)));

  // R8: a finished sum waits while the output slot is occupied
  a_r8_hold_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    (last_ph && !out_free) |=> busy_q);

endmodule

// File: rtl/sym_cfir_chain.sv
module sym_cfir_chain #(
  parameter int NTAPS   = 15,
  parameter int NSTAGES = 2,
  parameter int CPS     = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_data,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [31:0] m_data
);

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic               lk_valid [NSTAGES+1];
  logic               lk_ready [NSTAGES+1];
  logic signed [15:0] lk_re    [NSTAGES+1];
  logic signed [15:0] lk_im    [NSTAGES+1];

  assign lk_valid[0] = s_valid;
  assign lk_re[0]    = s_data[31:16];
  assign lk_im[0]    = s_data[15:0];
  assign s_ready     = lk_ready[0];

  for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
    cfir_stage #(.NTAPS(NTAPS), .CPS(CPS)) u_stage (
      .clk(clk), .rst_n(srst_n),
      .i_valid(lk_valid[s]), .i_ready(lk_ready[s]),
      .i_re(lk_re[s]), .i_im(lk_im[s]),
      .o_valid(lk_valid[s+1]), .o_ready(lk_ready[s+1]),
      .o_re(lk_re[s+1]), .o_im(lk_im[s+1])
    );
  end

  assign lk_ready[NSTAGES] = m_ready;
  assign m_valid = lk_valid[NSTAGES];
  assign m_data  = {lk_re[NSTAGES], lk_im[NSTAGES]};

endmodule

// File: tb/sym_cfir_chain_tb.sv
module sym_cfir_chain_tb;

  typedef int iq_t[$];

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic a_s_valid, a_s_ready, a_m_valid, a_m_ready;
  logic [31:0] a_s_data, a_m_data;
  logic b_s_valid, b_s_ready, b_m_valid, b_m_ready;
  logic [31:0] b_s_data, b_m_data;

  sym_cfir_chain #(.NTAPS(15), .NSTAGES(2), .CPS(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(a_s_valid), .s_ready(a_s_ready), .s_data(a_s_data),
    .m_valid(a_m_valid), .m_ready(a_m_ready), .m_data(a_m_data));

  sym_cfir_chain #(.NTAPS(16), .NSTAGES(1), .CPS(4)) u_dut_cps4 (
    .clk(clk), .rst_n(rst_n), .s_valid(b_s_valid), .s_ready(b_s_ready), .s_data(b_s_data),
    .m_valid(b_m_valid), .m_ready(b_m_ready), .m_data(b_m_data));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  iq_t stim_re, stim_im, got_re, got_im, exp_re, exp_im;
  int acc_cyc[$];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int coef_of(input int nt, input int k);
    return (k + 1 < nt - k) ? (k + 1) : (nt - k);
  endfunction

  function automatic int sh_of(input int nt);
    int s = 0;
    int r = 0;
    for (int k = 0; k < nt; k++) s += coef_of(nt, k);
    while ((s >> (r + 1)) != 0) r++;
    return r;
  endfunction

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic iq_t ref_pass(input int nt, input iq_t x);
    iq_t y;
    int sh = sh_of(nt);
    for (int n = 0; n < x.size(); n++) begin
      longint a = 0;
      for (int k = 0; k < nt; k++)
        if (n - k >= 0) a += longint'(coef_of(nt, k)) * longint'(x[n-k]);
      if (sh > 0) a = a + (longint'(1) << (sh - 1));
      a = a >>> sh;
      y.push_back(sat16(a));
    end
    return y;
  endfunction

  task automatic ref_chain(input int nt, input int nst);
    exp_re = stim_re;
    exp_im = stim_im;
    for (int s = 0; s < nst; s++) begin
      exp_re = ref_pass(nt, exp_re);
      exp_im = ref_pass(nt, exp_im);
    end
  endtask

  task automatic drive_src(input int sel, input logic v, input int re, input int im);
    logic [15:0] r16, i16;
    r16 = re[15:0];
    i16 = im[15:0];
    if (sel == 0) begin a_s_valid = v; a_s_data = {r16, i16}; end
    else          begin b_s_valid = v; b_s_data = {r16, i16}; end
  endtask

  task automatic drive_snk(input int sel, input logic r);
    if (sel == 0) a_m_ready = r; else b_m_ready = r;
  endtask

  function automatic logic src_rdy(input int sel);
    return (sel == 0) ? a_s_ready : b_s_ready;
  endfunction

  function automatic logic snk_vld(input int sel);
    return (sel == 0) ? a_m_valid : b_m_valid;
  endfunction

  function automatic int snk_re(input int sel);
    logic signed [15:0] v;
    v = (sel == 0) ? a_m_data[31:16] : b_m_data[31:16];
    return int'(v);
  endfunction

  function automatic int snk_im(input int sel);
    logic signed [15:0] v;
    v = (sel == 0) ? a_m_data[15:0] : b_m_data[15:0];
    return int'(v);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    drive_src(0, 0, 0, 0); drive_src(1, 0, 0, 0);
    drive_snk(0, 1); drive_snk(1, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input int sel, input int vpct);
    int i = 0;
    logic v = 0;
    while (i < stim_re.size() && !done) begin
      @(negedge clk);
      if (!v) v = ($urandom_range(99) < vpct);
      drive_src(sel, v, stim_re[i], stim_im[i]);
      #1;
      if (v && src_rdy(sel)) begin
        acc_cyc.push_back(cyc);
        i++;
        v = 0;
      end
    end
    @(negedge clk);
    drive_src(sel, 0, 0, 0);
  endtask

  task automatic recv(input int sel, input int rpct);
    logic r;
    while (got_re.size() < stim_re.size() && !done) begin
      @(negedge clk);
      r = ($urandom_range(99) < rpct);
      drive_snk(sel, r);
      #1;
      if (r && snk_vld(sel)) begin
        got_re.push_back(snk_re(sel));
        got_im.push_back(snk_im(sel));
      end
    end
    drive_snk(sel, 1);
  endtask

  task automatic run(input int sel, input int vpct, input int rpct);
    got_re = {}; got_im = {}; acc_cyc = {};
    fork
      send(sel, vpct);
      recv(sel, rpct);
    join
  endtask

  task automatic compare(input string req);
    chk(got_re.size() == exp_re.size(), req, "output count", got_re.size(), exp_re.size());
    for (int i = 0; i < exp_re.size() && i < got_re.size(); i++) begin
      chk(got_re[i] == exp_re[i], req, $sformatf("real[%0d]", i), got_re[i], exp_re[i]);
      chk(got_im[i] == exp_im[i], req, $sformatf("imag[%0d]", i), got_im[i], exp_im[i]);
    end
  endtask

  task automatic fill_random(input int n);
    stim_re = {}; stim_im = {};
    for (int i = 0; i < n; i++) begin
      stim_re.push_back(int'($urandom_range(65535)) - 32768);
      stim_im.push_back(int'($urandom_range(65535)) - 32768);
    end
  endtask

  // R9: state right after reset release
  task automatic t_reset();
    do_reset();
    chk(a_m_valid == 1'b0, "R9", "m_valid after reset", a_m_valid, 0);
    chk(a_s_ready == 1'b1, "R9", "s_ready after reset", a_s_ready, 1);
    chk(b_m_valid == 1'b0, "R9", "cps4 m_valid after reset", b_m_valid, 0);
    chk(b_s_ready == 1'b1, "R9", "cps4 s_ready after reset", b_s_ready, 1);
  endtask

  // R2, R1: impulse on single 16-tap stage gives coefficients
  task automatic t_impulse();
    do_reset();
    stim_re = {}; stim_im = {};
    for (int i = 0; i < 20; i++) begin
      stim_re.push_back(i == 0 ? 6400 : 0);
      stim_im.push_back(0);
    end
    run(1, 100, 100);
    for (int k = 0; k < 20 && k < got_re.size(); k++) begin
      chk(got_re[k] == ((k < 16) ? 100 * coef_of(16, k) : 0), "R2", $sformatf("impulse tap %0d", k),
          got_re[k], (k < 16) ? 100 * coef_of(16, k) : 0);
      chk(got_im[k] == 0, "R1", $sformatf("imag leak %0d", k), got_im[k], 0);
    end
    // R5 / R7: odd 15-tap two-stage chain, impulse on imaginary part only
    do_reset();
    stim_re = {}; stim_im = {};
    for (int i = 0; i < 36; i++) begin
      stim_re.push_back(0);
      stim_im.push_back(i == 0 ? -20000 : 0);
    end
    ref_chain(15, 2);
    run(0, 100, 100);
    compare("R5");
  endtask

  // R3: unity DC gain on 15 taps and half-up rounding on 16 taps
  task automatic t_round();
    do_reset();
    stim_re = {}; stim_im = {};
    for (int i = 0; i < 40; i++) begin stim_re.push_back(1000); stim_im.push_back(-500); end
    ref_chain(15, 2);
    run(0, 100, 100);
    compare("R3");
    if (got_re.size() == 40) begin
      chk(got_re[39] == 1000, "R3", "dc real", got_re[39], 1000);
      chk(got_im[39] == -500, "R3", "dc imag", got_im[39], -500);
    end
    do_reset();
    stim_re = {}; stim_im = {};
    for (int i = 0; i < 36; i++) begin
      stim_re.push_back(i == 0 ? 32 : (i == 18 ? -32 : 0));
      stim_im.push_back(0);
    end
    ref_chain(16, 1);
    run(1, 100, 100);
    compare("R3");
    if (got_re.size() == 36) begin
      chk(got_re[0] == 1, "R3", "+0.5 rounds up", got_re[0], 1);
      chk(got_re[2] == 2, "R3", "+1.5 rounds up", got_re[2], 2);
      chk(got_re[18] == 0, "R3", "-0.5 rounds up", got_re[18], 0);
      chk(got_re[20] == -1, "R3", "-1.5 rounds up", got_re[20], -1);
    end
  endtask

  // R4: full-scale DC on 16 taps (gain 72/64) saturates
  task automatic t_sat();
    do_reset();
    stim_re = {}; stim_im = {};
    for (int i = 0; i < 24; i++) begin stim_re.push_back(32767); stim_im.push_back(-32768); end
    ref_chain(16, 1);
    run(1, 100, 100);
    compare("R4");
    if (got_re.size() == 24) begin
      chk(got_re[23] == 32767, "R4", "positive clip", got_re[23], 32767);
      chk(got_im[23] == -32768, "R4", "negative clip", got_im[23], -32768);
    end
  endtask

  // R6: acceptance spacing equals CPS when never stalled
  task automatic t_rate();
    do_reset();
    fill_random(24);
    ref_chain(16, 1);
    run(1, 100, 100);
    compare("R5");
    for (int i = 1; i < acc_cyc.size(); i++)
      chk(acc_cyc[i] - acc_cyc[i-1] == 4, "R6", "cps4 accept spacing", acc_cyc[i] - acc_cyc[i-1], 4);
    do_reset();
    fill_random(30);
    ref_chain(15, 2);
    run(0, 100, 100);
    compare("R7");
    for (int i = 1; i < acc_cyc.size(); i++)
      chk(acc_cyc[i] - acc_cyc[i-1] == 1, "R6", "cps1 accept spacing", acc_cyc[i] - acc_cyc[i-1], 1);
  endtask

  // R8: random valid/ready, then no extra word may appear
  task automatic t_backpressure(input int sel, input int nt, input int nst);
    bit extra;
    do_reset();
    fill_random(60);
    ref_chain(nt, nst);
    run(sel, 60, 40);
    compare("R8");
    extra = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #1;
      if (snk_vld(sel)) extra = 1;
    end
    chk(extra == 0, "R8", "spurious output after stream", extra, 0);
  endtask

  // R10: pipeline latency from accept to output valid
  task automatic t_latency(input int sel, input int expn);
    int k;
    do_reset();
    drive_snk(sel, 1);
    @(negedge clk);
    drive_src(sel, 1, 123, -45);
    #1;
    chk(src_rdy(sel) == 1'b1, "R10", "idle input ready", src_rdy(sel), 1);
    k = 0;
    @(negedge clk);
    drive_src(sel, 0, 0, 0);
    #1;
    k = 1;
    while (!snk_vld(sel) && k < 40) begin
      @(negedge clk); #1;
      k++;
    end
    chk(k == expn, "R10", "negedges until m_valid", k, expn);
  endtask

  initial begin
    wait (cyc == 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    t_reset();
    t_impulse();
    t_round();
    t_sat();
    t_rate();
    t_backpressure(0, 15, 2);
    t_backpressure(1, 16, 1);
    t_latency(0, 4);
    t_latency(1, 5);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule